// File: doc/BRIEF.md
# Video Capture Bus Master

This block takes a 15-bit colour video stream from a small handheld-style LCD source and stores it in a byte-wide external memory through a shared system bus. The source provides three 5-bit colour channels, a vertical sync and its own pixel clock of roughly 2.4 MHz. Each pixel clock edge that falls outside vertical sync captures one pixel into an on-chip FIFO. The FIFO carries pixels into the 50 MHz system clock domain. On the system side a bus master empties the FIFO and stores each pixel as two byte writes into a linear framebuffer. The default framebuffer size is 240 by 160 pixels.

The block is one of several masters on the bus, so every write waits for an acknowledge for as long as the bus needs. A rising vertical sync, synchronised into the system clock, moves the write pointer back to the framebuffer base. If a pixel is only half written at that moment, its remaining byte is discarded. A pixel that arrives while the FIFO is full is dropped and sets a sticky overflow flag. Software clears that flag through a clear input.

Top module: `pix_capture_dma`

## Requirements
- R1: After reset, busCyc and busStb are low, busAdr equals BASE_ADDR and ovfFlag is low.
- R2: On each rising pixClk edge with pixVsync low, one pixel is captured, with bits [4:0] from pixRed, [9:5] from pixGrn and [14:10] from pixBlu. Rising pixClk edges with pixVsync high capture nothing.
- R3: Each pixel is written as two bytes. The first byte, at address A, is pixel bits [7:0]. The second byte, at A+1, is {1'b0, pixel bits [14:8]}.
- R4: The write address starts at BASE_ADDR and rises by one for each acknowledged byte. After the byte at BASE_ADDR + 2*FRAME_W*FRAME_H - 1, the address wraps back to BASE_ADDR.
- R5: busCyc, busStb and busWe are asserted together. Address and data stay unchanged until busAck is seen. Any number of wait cycles is tolerated.
- R6: A rising edge of pixVsync, after synchronisation into sysClk, makes BASE_ADDR the address of the next byte written.
- R7: If that restart arrives while a pixel still has unacknowledged bytes, busStb drops in the restart cycle and the remaining byte of that pixel is never written.
- R8: Pixels are written in the order they were captured, with none lost while the FIFO has room.
- R9: A pixel captured while the FIFO is full is dropped and sets ovfFlag. ovfFlag stays high until it is cleared.
- R10: ovfClr high on a sysClk edge makes ovfFlag low after that edge. Clearing takes priority over a new overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sysClk | input | 1 | System clock (50 MHz) |
| pixClk | input | 1 | Pixel clock from the video source |
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| pixRed | input | 5 | Red channel |
| pixGrn | input | 5 | Green channel |
| pixBlu | input | 5 | Blue channel |
| pixVsync | input | 1 | Vertical sync from the source, active high |
| busCyc | output | 1 | Bus cycle request |
| busStb | output | 1 | Bus strobe |
| busWe | output | 1 | Write enable |
| busAdr | output | ADDR_W | Byte address |
| busDat | output | 8 | Write data byte |
| busAck | input | 1 | Acknowledge from the bus |
| ovfFlag | output | 1 | Sticky FIFO overflow flag |
| ovfClr | input | 1 | Clears ovfFlag |

## Verification
The hardest case to reach from the ports is a vertical sync that arrives between the two bytes of one pixel. The bus must be holding the second byte at that moment, and the FIFO must be empty. The bench sets up this case with its bus model. The model acknowledges only after a long wait and watches busAdr until the high byte is on offer. At that point the model stops acknowledging and the bench raises the sync. The bench then counts the bytes that were written and checks that the abandoned byte never appears.

// File: rtl/pcd_pkg.sv
package pcd_pkg;
  // strobes from the bus control to the datapath
  typedef struct packed {
    logic pop;      // load next pixel from the FIFO
    logic advance;  // byte acknowledged, step address
    logic hiSel;    // present the high byte
  } pcdStrobe_t;

  typedef enum logic [1:0] {ST_IDLE, ST_LOW, ST_HIGH} pcdState_t;
endpackage

// File: rtl/pcd_async_fifo.sv
module pcd_async_fifo #(
  parameter int DW = 15,
  parameter int AW = 4
) (
  input  logic          wrClk,
  input  logic          rdClk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic [DW-1:0] wrData,
  output logic          full,
  input  logic          rdEn,
  output logic [DW-1:0] rdData,
  output logic          empty
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];
  logic [AW:0] wrBin, wrGray, rdBin, rdGray;
  logic [AW:0] rdGrayS1, rdGrayS2, wrGrayS1, wrGrayS2;
  logic [AW:0] wrBinNext, rdBinNext;

  assign wrBinNext = wrBin + 1'b1;
  assign rdBinNext = rdBin + 1'b1;

  // write domain
  always_ff @(posedge wrClk or negedge rstN) begin
    if (!rstN) begin
      wrBin <= '0;
      wrGray <= '0;
      rdGrayS1 <= '0;
      rdGrayS2 <= '0;
    end else begin
      rdGrayS1 <= rdGray;
      rdGrayS2 <= rdGrayS1;
      if (wrEn && !full) begin
        wrBin <= wrBinNext;
        wrGray <= wrBinNext ^ (wrBinNext >> 1);
      end
    end
  end

  always_ff @(posedge wrClk) begin
    if (wrEn && !full) store[wrBin[AW-1:0]] <= wrData;
  end

  assign full = (wrGray == {~rdGrayS2[AW:AW-1], rdGrayS2[AW-2:0]});

  // read domain
  always_ff @(posedge rdClk or negedge rstN) begin
    if (!rstN) begin
      rdBin <= '0;
      rdGray <= '0;
      wrGrayS1 <= '0;
      wrGrayS2 <= '0;
    end else begin
      wrGrayS1 <= wrGray;
      wrGrayS2 <= wrGrayS1;
      if (rdEn && !empty) begin
        rdBin <= rdBinNext;
        rdGray <= rdBinNext ^ (rdBinNext >> 1);
      end
    end
  end

  assign empty = (rdGray == wrGrayS2);
  assign rdData = store[rdBin[AW-1:0]];
endmodule

// File: rtl/pcd_datapath.sv
module pcd_datapath
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int FRAME_BYTES = 76800,
  parameter int FIFO_AW = 4
) (
  input  logic              sysClk,
  input  logic              pixClk,
  input  logic              rstN,
  input  logic [4:0]        pixRed,
  input  logic [4:0]        pixGrn,
  input  logic [4:0]        pixBlu,
  input  logic              pixVsync,
  input  pcdStrobe_t        strobe,
  output logic              fifoEmpty,
  output logic              frameStart,
  output logic [ADDR_W-1:0] busAdr,
  output logic [7:0]        busDat,
  output logic              ovfFlag,
  input  logic              ovfClr
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = BASE_ADDR + ADDR_W'(FRAME_BYTES - 1);

  logic        fifoFull, pixWr, ovfTgl;
  logic [14:0] fifoOut, curPix;
  logic [2:0]  vsSync, ovfSync;

  assign pixWr = !pixVsync;

  pcd_async_fifo #(.DW(15), .AW(FIFO_AW)) u_fifo (
    .wrClk (pixClk),
    .rdClk (sysClk),
    .rstN  (rstN),
    .wrEn  (pixWr),
    .wrData({pixBlu, pixGrn, pixRed}),
    .full  (fifoFull),
    .rdEn  (strobe.pop),
    .rdData(fifoOut),
    .empty (fifoEmpty)
  );

  // a dropped pixel flips a toggle that the system side watches
  always_ff @(posedge pixClk or negedge rstN) begin
    if (!rstN) ovfTgl <= 1'b0;
    else if (pixWr && fifoFull) ovfTgl <= ~ovfTgl;
  end

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) begin
      vsSync <= '0;
      ovfSync <= '0;
      ovfFlag <= 1'b0;
      curPix <= '0;
      busAdr <= BASE_ADDR;
    end else begin
      vsSync <= {vsSync[1:0], pixVsync};
      ovfSync <= {ovfSync[1:0], ovfTgl};
      if (ovfClr) ovfFlag <= 1'b0;
      else if (ovfSync[2] ^ ovfSync[1]) ovfFlag <= 1'b1;
      if (strobe.pop) curPix <= fifoOut;
      if (frameStart) busAdr <= BASE_ADDR;
      else if (strobe.advance) busAdr <= (busAdr == LAST_ADDR) ? BASE_ADDR : busAdr + 1'b1;
    end
  end

  assign frameStart = vsSync[1] & ~vsSync[2];
  assign busDat = strobe.hiSel ? {1'b0, curPix[14:8]} : curPix[7:0];
endmodule

// File: rtl/pcd_control.sv
module pcd_control
  import pcd_pkg::*;
(
  input  logic       sysClk,
  input  logic       rstN,
  input  logic       fifoEmpty,
  input  logic       frameStart,
  input  logic       busAck,
  output logic       busCyc,
  output logic       busStb,
  output logic       busWe,
  output pcdStrobe_t strobe
);
  pcdState_t state;

  always_ff @(posedge sysClk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else if (frameStart) state <= ST_IDLE;
    else begin
      case (state)
        ST_IDLE: if (!fifoEmpty) state <= ST_LOW;
        ST_LOW:  if (busAck) state <= ST_HIGH;
        ST_HIGH: if (busAck) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    busStb = (state != ST_IDLE) && !frameStart;
    busCyc = busStb;
    busWe = busStb;
    strobe.pop = (state == ST_IDLE) && !fifoEmpty && !frameStart;
    strobe.advance = busStb && busAck;
    strobe.hiSel = (state == ST_HIGH);
  end
endmodule

// File: rtl/pix_capture_dma.sv
module pix_capture_dma
  import pcd_pkg::*;
#(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0,
  parameter int FRAME_W = 240,
  parameter int FRAME_H = 160,
  parameter int FIFO_AW = 4
) (
  input  logic              sysClk,
  input  logic              pixClk,
  input  logic              rstN,
  input  logic [4:0]        pixRed,
  input  logic [4:0]        pixGrn,
  input  logic [4:0]        pixBlu,
  input  logic              pixVsync,
  output logic              busCyc,
  output logic              busStb,
  output logic              busWe,
  output logic [ADDR_W-1:0] busAdr,
  output logic [7:0]        busDat,
  input  logic              busAck,
  output logic              ovfFlag,
  input  logic              ovfClr
);
  localparam int FRAME_BYTES = FRAME_W * FRAME_H * 2;

  pcdStrobe_t strobe;
  logic       fifoEmpty, frameRestart;

  pcd_datapath #(
    .ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR),
    .FRAME_BYTES(FRAME_BYTES), .FIFO_AW(FIFO_AW)
  ) u_dp (
    .sysClk(sysClk), .pixClk(pixClk), .rstN(rstN),
    .pixRed(pixRed), .pixGrn(pixGrn), .pixBlu(pixBlu), .pixVsync(pixVsync),
    .strobe(strobe), .fifoEmpty(fifoEmpty), .frameStart(frameRestart),
    .busAdr(busAdr), .busDat(busDat), .ovfFlag(ovfFlag), .ovfClr(ovfClr)
  );

  pcd_control u_ctl (
    .sysClk(sysClk), .rstN(rstN), .fifoEmpty(fifoEmpty),
    .frameStart(frameRestart), .busAck(busAck),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .strobe(strobe)
  );
endmodule

// File: rtl/pcd_checker.sv
module pcd_checker #(
  parameter int ADDR_W = 19,
  parameter logic [ADDR_W-1:0] BASE_ADDR = '0
) (
  input logic              sysClk,
  input logic              rstN,
  input logic              busCyc,
  input logic              busStb,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAdr,
  input logic [7:0]        busDat,
  input logic              busAck,
  input logic              ovfFlag,
  input logic              ovfClr,
  input logic              frameRestart
);
  AST_BUS_WRITE: assert property (@(posedge sysClk) disable iff (!rstN)
    busStb |-> (busCyc && busWe)); // R5
  AST_HOLD_REQ: assert property (@(posedge sysClk) disable iff (!rstN)
    (busStb && !busAck) |=> ($stable(busAdr) && $stable(busDat))); // R5
  AST_ADDR_STEP: assert property (@(posedge sysClk) disable iff (!rstN)
    (busStb && busAck) |=> ((busAdr == $past(busAdr) + 1'b1) || (busAdr == BASE_ADDR))); // R4
  AST_RESTART_BASE: assert property (@(posedge sysClk) disable iff (!rstN)
    frameRestart |=> (busAdr == BASE_ADDR && !busStb)); // R6
  AST_RESTART_DROP: assert property (@(posedge sysClk) disable iff (!rstN)
    frameRestart |-> !busStb); // R7
  AST_OVF_STICKY: assert property (@(posedge sysClk) disable iff (!rstN)
    (ovfFlag && !ovfClr) |=> ovfFlag); // R9
  AST_OVF_CLEAR: assert property (@(posedge sysClk) disable iff (!rstN)
    ovfClr |=> !ovfFlag); // R10
endmodule

bind pix_capture_dma pcd_checker #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_chk (
  .sysClk(sysClk), .rstN(rstN), .busCyc(busCyc), .busStb(busStb), .busWe(busWe),
  .busAdr(busAdr), .busDat(busDat), .busAck(busAck), .ovfFlag(ovfFlag),
  .ovfClr(ovfClr), .frameRestart(frameRestart)
);

// File: tb/pix_capture_dma_bench.sv
module pix_capture_dma_bench;
  localparam int SYS_PERIOD = 20;
  localparam int PIX_PERIOD = 400;
  localparam int AW = 19;
  localparam logic [AW-1:0] BASE = 19'h00100;
  localparam int FW = 4;
  localparam int FH = 3;
  localparam int FIFO_AW = 3;
  localparam int DEPTH = 1 << FIFO_AW;
  localparam int NPIX = FW * FH;

  typedef struct packed {
    logic [14:0] pix;
    logic [7:0]  lo;
    logic [7:0]  hi;
  } vec_t;

  // R3: lo = pix[7:0], hi = {0, pix[14:8]}
  localparam vec_t VECS [NPIX] = '{
    '{15'h7FFF, 8'hFF, 8'h7F}, '{15'h0000, 8'h00, 8'h00},
    '{15'h001F, 8'h1F, 8'h00}, '{15'h03E0, 8'hE0, 8'h03},
    '{15'h7C00, 8'h00, 8'h7C}, '{15'h5555, 8'h55, 8'h55},
    '{15'h2AAA, 8'hAA, 8'h2A}, '{15'h0100, 8'h00, 8'h01},
    '{15'h00FF, 8'hFF, 8'h00}, '{15'h4080, 8'h80, 8'h40},
    '{15'h1234, 8'h34, 8'h12}, '{15'h7ABC, 8'hBC, 8'h7A}
  };

  logic sysClk = 1'b0, pixClk = 1'b0, rstN = 1'b0;
  logic [4:0] pixRed = '0, pixGrn = '0, pixBlu = '0;
  logic pixVsync = 1'b0, busAck, ovfClr = 1'b0;
  logic busCyc, busStb, busWe, ovfFlag;
  logic [AW-1:0] busAdr;
  logic [7:0] busDat;

  logic [7:0] mem [512];
  int writeCount = 0;
  int latency = 0;
  int waitCnt = 0;
  logic holdAck = 1'b0;
  int tests = 0, fails = 0;
  bit done = 0;

  pix_capture_dma #(.ADDR_W(AW), .BASE_ADDR(BASE), .FRAME_W(FW), .FRAME_H(FH),
                    .FIFO_AW(FIFO_AW)) u_pix_capture_dma (
    .sysClk(sysClk), .pixClk(pixClk), .rstN(rstN),
    .pixRed(pixRed), .pixGrn(pixGrn), .pixBlu(pixBlu), .pixVsync(pixVsync),
    .busCyc(busCyc), .busStb(busStb), .busWe(busWe), .busAdr(busAdr),
    .busDat(busDat), .busAck(busAck), .ovfFlag(ovfFlag), .ovfClr(ovfClr)
  );

  always #(SYS_PERIOD/2) sysClk = ~sysClk;

  // bus slave model with programmable wait and hold
  always @(posedge sysClk) begin
    if (!rstN) begin
      busAck <= 1'b0;
      waitCnt <= 0;
    end else if (busStb && !busAck && !holdAck) begin
      if (waitCnt >= latency) begin
        busAck <= 1'b1;
        mem[busAdr[8:0]] <= busDat;
        writeCount <= writeCount + 1;
        waitCnt <= 0;
      end else waitCnt <= waitCnt + 1;
    end else begin
      busAck <= 1'b0;
      if (!busStb) waitCnt <= 0;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pushPix(input logic [14:0] p, input logic vs);
    pixRed = p[4:0];
    pixGrn = p[9:5];
    pixBlu = p[14:10];
    pixVsync = vs;
    #(PIX_PERIOD/2) pixClk = 1'b1;
    #(PIX_PERIOD/2) pixClk = 1'b0;
  endtask

  task automatic vsyncPulse();
    for (int k = 0; k < 3; k++) pushPix(15'h7FFF, 1'b1);
    pixVsync = 1'b0;
    repeat (10) @(negedge sysClk);
  endtask

  task automatic clearMem();
    for (int k = 0; k < 512; k++) mem[k] = 8'hEE;
  endtask

  task automatic settle();
    repeat (400) @(negedge sysClk);
  endtask

  function automatic logic [15:0] word(input int idx);
    return {mem[idx+1], mem[idx]};
  endfunction

  initial begin
    #(SYS_PERIOD * 150000);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int wc0;
    int b;
    clearMem();
    b = int'(BASE[8:0]);
    repeat (5) @(negedge sysClk);
    rstN = 1'b1;
    @(negedge sysClk);
    // R1 reset state
    check(!busCyc && !busStb, "R1 bus idle", {busCyc, busStb}, 0);
    check(busAdr == BASE, "R1 base addr", busAdr, BASE);
    check(!ovfFlag, "R1 ovf low", ovfFlag, 0);

    // table walk, zero wait
    wc0 = writeCount;
    vsyncPulse();
    check(writeCount == wc0, "R2 vsync ignored", writeCount - wc0, 0);
    for (int i = 0; i < NPIX; i++) pushPix(VECS[i].pix, 1'b0);
    settle();
    for (int i = 0; i < NPIX; i++)
      check(word(b + 2*i) == {VECS[i].hi, VECS[i].lo}, "R3 R8 table byte pair",
            word(b + 2*i), {VECS[i].hi, VECS[i].lo});
    check(writeCount - wc0 == 2*NPIX, "R2 byte count", writeCount - wc0, 2*NPIX);

    // R4 wrap after full frame
    pushPix(15'h0ACE, 1'b0);
    settle();
    check(word(b) == 16'h0ACE, "R4 wrap to base", word(b), 16'h0ACE);
    check(mem[b + 2*NPIX] == 8'hEE, "R4 no write past frame", mem[b + 2*NPIX], 8'hEE);

    // R5 stalled bus
    latency = 7;
    vsyncPulse();
    clearMem();
    for (int i = 5; i < 9; i++) pushPix(VECS[i].pix, 1'b0);
    settle();
    for (int i = 0; i < 4; i++)
      check(word(b + 2*i) == {VECS[i+5].hi, VECS[i+5].lo}, "R5 stalled writes",
            word(b + 2*i), {VECS[i+5].hi, VECS[i+5].lo});

    // R6 mid-frame restart
    latency = 0;
    vsyncPulse();
    pushPix(15'h1357, 1'b0);
    settle();
    check(word(b) == 16'h1357, "R6 restart to base", word(b), 16'h1357);
    check(word(b + 2) == {VECS[6].hi, VECS[6].lo}, "R6 old data kept",
          word(b + 2), {VECS[6].hi, VECS[6].lo});

    // R7 restart between low and high byte
    latency = 20;
    vsyncPulse();
    clearMem();
    wc0 = writeCount;
    pushPix(15'h4321, 1'b0);
    for (int k = 0; k < 300; k++) begin
      @(negedge sysClk);
      if (busStb && busAdr == BASE + 19'd1) break;
    end
    holdAck = 1'b1;
    vsyncPulse();
    check(!busStb && busAdr == BASE, "R7 cycle dropped", {busStb, busAdr}, {1'b0, BASE});
    holdAck = 1'b0;
    latency = 0;
    pushPix(15'h2468, 1'b0);
    settle();
    check(writeCount - wc0 == 3, "R7 partial byte discarded", writeCount - wc0, 3);
    check(word(b) == 16'h2468, "R7 next pixel at base", word(b), 16'h2468);
    check(mem[b + 2] == 8'hEE, "R7 nothing further", mem[b + 2], 8'hEE);
    check(!ovfFlag, "R9 no false overflow", ovfFlag, 0);

    // R9 overflow, R10 clear
    holdAck = 1'b1;
    vsyncPulse();
    for (int k = 0; k < DEPTH + 3; k++) pushPix(15'(k), 1'b0);
    repeat (10) @(negedge sysClk);
    check(ovfFlag, "R9 overflow set", ovfFlag, 1);
    repeat (50) @(negedge sysClk);
    check(ovfFlag, "R9 overflow sticky", ovfFlag, 1);
    ovfClr = 1'b1;
    @(negedge sysClk);
    ovfClr = 1'b0;
    check(!ovfFlag, "R10 overflow cleared", ovfFlag, 0);
    holdAck = 1'b0;
    settle();
    check(!ovfFlag, "R10 stays clear", ovfFlag, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule